// File: doc/BRIEF.md
# Serial Flash Status Write Guard

This block is the part of a serial-flash slave that accepts writes to the status register. It oversamples the serial clock, active-low select, serial data and active-low write-protect pin on a fast system clock. Data bits are taken on each rising serial-clock edge, so the host may idle the clock low (mode 0) or high (mode 3). A transaction starts when select falls and ends when select rises. All decisions are made on the rising edge of select, using the number of bits counted and the first eight bits received, which are the opcode.

A write sequence has two parts. First, one transaction sends a single enable opcode, which sets a write-enable latch. Then a second transaction sends the status-write opcode and one data byte. When that second transaction ends, the four protect-level bits and the lock bit are updated together, unless the lock rule blocks the write. The lock rule applies only while the protect pin is low. In that state the lock bit can be set but cannot be cleared, and once the lock bit is set, every later status write is discarded.

The enable latch is cleared by every status-write transaction, whether or not it commits. Transactions with the wrong length are discarded.

Top module: `spi_sr_lock`

## Requirements
- R1: After reset, `status` is 0x3C (protect-level bits 5..2 at their default 4'b1111, lock bit 7 clear) and `wel` is 0.
- R2: A transaction of exactly 8 bits whose opcode is 0x06 or 0x50 sets `wel` to 1 when select rises.
- R3: A transaction of exactly 16 bits with opcode 0x01, sent while `wel` is 1 and no lock is in force, copies data bits 5..2 into status bits 5..2 and data bit 7 into status bit 7 when select rises. Status does not change while select is still low.
- R4: Status bits 0, 1 and 6 always read 0, whatever data is written.
- R5: A status write (opcode 0x01, 16 bits) sent while `wel` is 0 leaves `status` unchanged.
- R6: While `wp_n` is low and status bit 7 is 1, a status write leaves every status bit unchanged.
- R7: While `wp_n` is low and status bit 7 is 0, a single status write can set bit 7 and change bits 5..2 at the same time.
- R8: While `wp_n` is high, a status write can clear bit 7 and rewrite bits 5..2 freely.
- R9: A transaction with a bit count different from its opcode's length changes no status bit and does not set `wel`. The length is 8 bits for the enable opcodes and 16 bits for 0x01. Both shorter and longer counts are covered.
- R10: Every transaction of at least 8 bits whose opcode is 0x01 clears `wel` when select rises, whether or not it commits.
- R11: Bits are taken on rising `sck` in both clock polarities, idle low and idle high.
- R12: `wp_n` and `cs_n` pass through synchronizers of equal depth, so the `wp_n` level presented together with the rising edge of `cs_n` is the level that decides that commit.
- R13: A transaction with any other opcode changes neither `status` nor `wel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; its rising edge ends a transaction |
| mosi | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Active-low write-protect pin |
| status | output | 8 | Status register: bit 7 lock, bits 5..2 protect level, others 0 |
| wel | output | 1 | Write-enable latch |

## Verification
The commit decision and a change of the protect pin can fall in the same system cycle. This happens when the host releases select at the same moment it moves `wp_n`. The bench provokes it in both directions. In one case it raises `wp_n` together with the select rise of a write that would otherwise be locked, and expects the write to commit. In the other case it lowers `wp_n` together with that rise while the lock bit is set, and expects the write to be discarded. The random transactions also change the pin at the end of each transaction, and a model judges every one of them using the pin level present at the select rise.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int SR_W      = 8;
  localparam int OPC_W     = 8;
  localparam int BP_LSB    = 2;
  localparam int BP_W      = 4;
  localparam int LOCK_POS  = 7;
  localparam logic [OPC_W-1:0] OPC_WR_EN = 8'h06;
  localparam logic [OPC_W-1:0] OPC_SR_EN = 8'h50;
  localparam logic [OPC_W-1:0] OPC_SR_WR = 8'h01;

  typedef struct packed {
    logic sck;
    logic cs_n;
    logic mosi;
    logic wp_n;
  } pins_t;
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sr_frame.sv
module spi_sr_frame #(
  parameter int OP_BITS  = 8,
  parameter int DAT_BITS = 8,
  localparam int TOT = OP_BITS + DAT_BITS,
  localparam int CW  = $clog2(TOT + 2),
  localparam int SHW = (OP_BITS > DAT_BITS) ? OP_BITS : DAT_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_s,
  input  logic                cs_s,
  input  logic                mosi_s,
  output logic                cs_rise,
  output logic [CW-1:0]       cnt,
  output logic [OP_BITS-1:0]  op,
  output logic [DAT_BITS-1:0] dat
);
  logic          sck_p, cs_p;
  logic          sck_rise, cs_fall;
  logic [SHW-1:0] sh_q;
  logic [CW-1:0]  cnt_q;
  logic [OP_BITS-1:0] op_q;

  assign sck_rise = sck_s & ~sck_p;
  assign cs_fall  = ~cs_s & cs_p;
  assign cs_rise  = cs_s & ~cs_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= 1'b0;
      cs_p  <= 1'b1;
      cnt_q <= '0;
      sh_q  <= '0;
      op_q  <= '0;
    end else begin
      sck_p <= sck_s;
      cs_p  <= cs_s;
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (sck_rise && !cs_s) begin
        sh_q <= {sh_q[SHW-2:0], mosi_s};
        if (cnt_q != CW'(TOT + 1)) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(OP_BITS - 1)) op_q <= {sh_q[OP_BITS-2:0], mosi_s};
      end
    end
  end

  assign cnt = cnt_q;
  assign op  = op_q;
  assign dat = sh_q[DAT_BITS-1:0];

  // R9
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(TOT + 1));

  // R9
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= CW'(OP_BITS)) |=> $stable(op_q));
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
  import spi_sr_pkg::*;
#(
  parameter logic [BP_W-1:0] INIT_BP = '1,
  parameter int OP_BITS  = 8,
  parameter int DAT_BITS = 8,
  localparam int TOT = OP_BITS + DAT_BITS,
  localparam int CW  = $clog2(TOT + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_rise,
  input  logic [CW-1:0]       cnt,
  input  logic [OP_BITS-1:0]  op,
  input  logic [DAT_BITS-1:0] dat,
  input  logic                wp_s,
  output logic [SR_W-1:0]     status,
  output logic                wel
);
  logic [BP_W-1:0] bp_q;
  logic            bpl_q;
  logic            wel_q;
  logic            locked, is_en, is_wr;

  assign locked = bpl_q & ~wp_s;
  assign is_en  = (cnt == CW'(OP_BITS)) && ((op == OPC_WR_EN) || (op == OPC_SR_EN));
  assign is_wr  = (cnt >= CW'(OP_BITS)) && (op == OPC_SR_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q  <= INIT_BP;
      bpl_q <= 1'b0;
      wel_q <= 1'b0;
    end else if (cs_rise) begin
      if (is_en) begin
        wel_q <= 1'b1;
      end else if (is_wr) begin
        wel_q <= 1'b0;
        if (cnt == CW'(TOT) && wel_q && !locked) begin
          bp_q  <= dat[BP_LSB +: BP_W];
          bpl_q <= dat[LOCK_POS];
        end
      end
    end
  end

  always_comb begin
    status           = '0;
    status[BP_LSB +: BP_W] = bp_q;
    status[LOCK_POS] = bpl_q;
  end
  assign wel = wel_q;

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bpl_q && !wp_s) |=> bpl_q);

  // R5
  no_wel_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !wel_q) |=> $stable({bpl_q, bp_q}));

  // R3
  commit_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_rise |=> $stable({bpl_q, bp_q}));

  // R10
  wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && cnt >= CW'(OP_BITS) && op == OPC_SR_WR) |=> !wel_q);
endmodule

// File: rtl/spi_sr_lock.sv
module spi_sr_lock
  import spi_sr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BP_W-1:0] INIT_BP = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sck,
  input  logic            cs_n,
  input  logic            mosi,
  input  logic            wp_n,
  output logic [SR_W-1:0] status,
  output logic            wel
);
  localparam int TOT = OPC_W + SR_W;
  localparam int CW  = $clog2(TOT + 2);
  localparam pins_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0, wp_n: 1'b1};

  pins_t pin_raw, pin_s;
  logic                cs_rise;
  logic [CW-1:0]       cnt;
  logic [OPC_W-1:0]    op;
  logic [SR_W-1:0]     dat;

  assign pin_raw = '{sck: sck, cs_n: cs_n, mosi: mosi, wp_n: wp_n};

  spi_sr_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
  );

  spi_sr_frame #(.OP_BITS(OPC_W), .DAT_BITS(SR_W)) u_frame (
    .clk(clk), .rst(rst), .sck_s(pin_s.sck), .cs_s(pin_s.cs_n), .mosi_s(pin_s.mosi),
    .cs_rise(cs_rise), .cnt(cnt), .op(op), .dat(dat)
  );

  spi_sr_ctrl #(.INIT_BP(INIT_BP), .OP_BITS(OPC_W), .DAT_BITS(SR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .cnt(cnt), .op(op), .dat(dat),
    .wp_s(pin_s.wp_n), .status(status), .wel(wel)
  );
endmodule

// File: tb/tb_spi_sr_lock.sv
module tb_spi_sr_lock;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic [7:0] status;
  logic       wel;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] m_st = 8'h3C;
  logic       m_wel = 1'b0;

  always #2 clk = ~clk;

  spi_sr_lock dut (.clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
                   .wp_n(wp_n), .status(status), .wel(wel));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] op, input logic [7:0] dat, input int n,
                      input bit m3, input bit wp_mid, input bit wp_end, input string req);
    logic [31:0] st;
    st = {op, dat, 16'($urandom)};
    wp_n = wp_mid;
    sck  = m3;
    idle(HALF);
    cs_n = 1'b0;
    idle(HALF);
    for (int i = 0; i < n; i++) begin
      if (m3) sck = 1'b0;
      mosi = st[31-i];
      idle(HALF);
      sck = 1'b1;
      idle(HALF);
      if (!m3) sck = 1'b0;
    end
    idle(HALF);
    chk({req, " R3 no change before select rise"}, status, m_st);
    cs_n = 1'b1;
    wp_n = wp_end;
    idle(10);
    if (n == 8 && (op == 8'h06 || op == 8'h50)) begin
      m_wel = 1'b1;
    end else if (n >= 8 && op == 8'h01) begin
      if (n == 16 && m_wel && !(m_st[7] && !wp_end))
        m_st = (m_st & ~8'hBC) | (dat & 8'hBC);
      m_wel = 1'b0;
    end
    chk({req, " status"}, status, m_st);
    chk({req, " wel"}, {7'd0, wel}, {7'd0, m_wel});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rop;
    int rn;
    void'($urandom(32'd1234));
    idle(5);
    rst = 1'b0;
    idle(3);
    // R1
    chk("R1 reset status", status, 8'h3C);
    chk("R1 reset wel", {7'd0, wel}, 8'h00);
    // R5
    xfer(8'h01, 8'h00, 16, 0, 1, 1, "R5 write without enable");
    // R2
    xfer(8'h06, 8'h00, 8, 0, 1, 1, "R2 enable 06");
    // R3 R4 R10
    xfer(8'h01, 8'hFF, 16, 0, 1, 1, "R3 R4 R10 commit FF");
    // R11 R2 R8
    xfer(8'h50, 8'h00, 8, 1, 1, 1, "R11 R2 enable 50 mode3");
    xfer(8'h01, 8'h00, 16, 1, 1, 1, "R11 R8 clear lock wp high");
    // R7
    xfer(8'h06, 8'h00, 8, 0, 0, 0, "R7 enable");
    xfer(8'h01, 8'h94, 16, 0, 0, 0, "R7 set lock and level wp low");
    // R6
    xfer(8'h06, 8'h00, 8, 1, 0, 0, "R6 enable");
    xfer(8'h01, 8'h00, 16, 1, 0, 0, "R6 locked write ignored");
    // R12 pin rises with select
    xfer(8'h06, 8'h00, 8, 0, 0, 0, "R12 enable");
    xfer(8'h01, 8'h00, 16, 0, 0, 1, "R12 wp rises with select");
    xfer(8'h06, 8'h00, 8, 0, 0, 0, "R12 enable");
    xfer(8'h01, 8'h80, 16, 0, 0, 0, "R12 relock");
    xfer(8'h06, 8'h00, 8, 0, 1, 1, "R12 enable");
    xfer(8'h01, 8'h3C, 16, 0, 1, 0, "R12 wp falls with select");
    // R9
    xfer(8'h01, 8'h00, 16, 0, 1, 1, "R9 unlock prep");
    xfer(8'h06, 8'h00, 8, 0, 1, 1, "R9 enable");
    xfer(8'h01, 8'h00, 16, 0, 1, 1, "R9 unlock");
    xfer(8'h06, 8'h00, 8, 0, 1, 1, "R9 enable");
    xfer(8'h01, 8'hA8, 15, 0, 1, 1, "R9 short write");
    xfer(8'h06, 8'h00, 9, 0, 1, 1, "R9 long enable");
    xfer(8'h06, 8'h00, 7, 1, 1, 1, "R9 short enable");
    xfer(8'h06, 8'h00, 8, 0, 1, 1, "R9 enable");
    xfer(8'h01, 8'hA8, 17, 1, 1, 1, "R9 long write");
    // R13
    xfer(8'h06, 8'h00, 8, 0, 1, 1, "R13 enable");
    xfer(8'hAB, 8'hFF, 16, 0, 1, 1, "R13 other opcode");
    xfer(8'h05, 8'h00, 8, 1, 1, 1, "R13 other opcode short");
    // random mix
    for (int t = 0; t < 220; t++) begin
      case ($urandom_range(0, 4))
        0: rop = 8'h06;
        1: rop = 8'h50;
        2, 3: rop = 8'h01;
        default: rop = 8'($urandom);
      endcase
      case ($urandom_range(0, 5))
        0: rn = $urandom_range(1, 20);
        1, 2: rn = 8;
        default: rn = 16;
      endcase
      if (rop != 8'h01 && rn == 16 && $urandom_range(0, 1) == 0) rn = 8;
      xfer(rop, 8'($urandom), rn, 1'($urandom), 1'($urandom), 1'($urandom),
           "random R3 R6 R7 R8 R10");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule